// File: doc/BRIEF.md
# PS/2 Host Port Controller

This block is one host-side PS/2 port. It works the open-drain clock and data lines through a pair of active-high "pull low" enables. It reads the line levels back through a two-flop synchronizer and a majority-free glitch filter. A small register port gives software access to a transmit byte, a received byte, a status word, an interrupt mask and an inhibit prescaler.

To send a byte, software writes the transmit register. The port holds the clock low for a programmed number of system clocks. It then asserts a start bit on data and releases the clock. After that it moves to the next bit on each falling clock edge that the device generates. At the end it checks for the device's acknowledge and reports success or a missed acknowledge; it never retries on its own.

When the port is idle, it captures device-to-host frames into the receive register. Any status bit whose mask bit is set raises the interrupt.

Top module: `ps2_host_port`

## Requirements
- R1: After reset, neither line is driven low, the status word is 3'b010 (bit 0 RXRDY = 0, bit 1 TXRDY = 1, bit 2 NACK = 0), the mask reads 0, and `irq` is low.
- R2: A write to address 0 (transmit) while the port is idle drives the clock low for exactly as many system clocks as the prescaler (address 6) holds. Data stays released during that time.
- R3: In the cycle that the clock is released at the end of the inhibit period, data is driven low as the start bit.
- R4: On successive device falling edges, the port presents data bits 0 to 7 (LSB first), then an odd parity bit, then a released (high) stop bit.
- R5: If data is low at the eleventh falling edge (the acknowledge), TXRDY becomes 1 and NACK stays 0.
- R6: If data is high at the eleventh falling edge, both TXRDY and NACK become 1, and the clock is not driven low again until software writes another byte.
- R7: A transmit write clears TXRDY and NACK.
- R8: A device frame made of a low start bit, 8 data bits (LSB first), correct odd parity and a high stop bit loads the byte at address 1 and sets RXRDY.
- R9: A frame with wrong parity or a low stop bit is dropped, and RXRDY stays 0.
- R10: Reading address 1 clears RXRDY.
- R11: Writing ones to address 3 sets mask bits, writing ones to address 4 clears them, and address 5 returns the mask. Bit positions match the status word.
- R12: `irq` is high exactly when some status bit and its mask bit are both 1.
- R13: A pulse on either line that is shorter than FILT system clocks does not reach the bus state machines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_in | input | 1 | Sensed level of the PS/2 clock line |
| ps2_dat_in | input | 1 | Sensed level of the PS/2 data line |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_dat_oe | output | 1 | 1 pulls the data line low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the port with PRESC_W = 8 and FILT = 3, and programs an inhibit of 20 clocks in place of a real 100 µs count. This keeps complete transmit and receive frames, including the no-acknowledge path, short enough for a directed run, and makes the inhibit length countable cycle by cycle. With FILT = 3, a one-cycle clock glitch placed just before a real frame shows whether the filter keeps the receiver aligned.

// File: rtl/ps2_host_port.sv
module ps2_host_port #(
  parameter int PRESC_W = 16,
  parameter int FILT    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ps2_clk_in,
  input  logic        ps2_dat_in,
  output logic        ps2_clk_oe,
  output logic        ps2_dat_oe,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq
);
  localparam logic [2:0] A_TX = 3'd0, A_RX = 3'd1, A_ST = 3'd2, A_IEN = 3'd3,
                         A_IDIS = 3'd4, A_MASK = 3'd5, A_PS = 3'd6;

  typedef enum logic [1:0] {T_IDLE, T_INH, T_BITS} tx_t;

  logic [1:0] s0, s1;
  logic [FILT-1:0] hc, hd;
  logic cf, df, cf_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s0 <= '1; s1 <= '1; hc <= '1; hd <= '1; cf <= 1'b1; df <= 1'b1; cf_d <= 1'b1;
    end else begin
      s0 <= {ps2_clk_in, ps2_dat_in};
      s1 <= s0;
      hc <= {hc[FILT-2:0], s1[1]};
      hd <= {hd[FILT-2:0], s1[0]};
      if (&hc) cf <= 1'b1; else if (~|hc) cf <= 1'b0;
      if (&hd) df <= 1'b1; else if (~|hd) df <= 1'b0;
      cf_d <= cf;
    end
  wire fall = cf_d & ~cf;

  tx_t tst;
  logic [PRESC_W-1:0] presc, cnt;
  logic [PRESC_W:0] cnt_nx;
  logic [7:0] txb, rxb;
  logic [3:0] tn, rn;
  logic [8:0] rsh;
  logic clk_lo, dat_lo, rxrdy, txrdy, nack;
  logic [2:0] mask;

  assign cnt_nx = {1'b0, cnt} + {{PRESC_W{1'b0}}, 1'b1};
  wire wr_tx   = reg_wr && reg_addr == A_TX && tst == T_IDLE;
  wire rd_rx   = reg_rd && reg_addr == A_RX;
  wire tx_done = tst == T_BITS && fall && tn == 4'd10;
  wire rx_ok   = tst == T_IDLE && fall && rn == 4'd10 && df && (^rsh);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tst <= T_IDLE; cnt <= '0; txb <= '0; tn <= '0; clk_lo <= 1'b0; dat_lo <= 1'b0;
    end else case (tst)
      T_IDLE: if (wr_tx) begin
        txb <= reg_wdata[7:0]; cnt <= '0; clk_lo <= 1'b1; tst <= T_INH;
      end
      T_INH: if (cnt_nx >= {1'b0, presc}) begin
        clk_lo <= 1'b0; dat_lo <= 1'b1; tn <= '0; tst <= T_BITS;
      end else cnt <= cnt_nx[PRESC_W-1:0];
      T_BITS: if (fall) begin
        tn <= tn + 4'd1;
        if (tn < 4'd8)       dat_lo <= ~txb[tn[2:0]];
        else if (tn == 4'd8) dat_lo <= ^txb;
        else if (tn == 4'd9) dat_lo <= 1'b0;
        else                 tst <= T_IDLE;
      end
      default: tst <= T_IDLE;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rn <= '0; rsh <= '0;
    end else if (tst != T_IDLE) rn <= '0;
    else if (fall) begin
      if (rn == 4'd0) begin
        if (!df) rn <= 4'd1;
      end else if (rn <= 4'd9) begin
        rsh <= {df, rsh[8:1]}; rn <= rn + 4'd1;
      end else rn <= '0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxrdy <= 1'b0; txrdy <= 1'b1; nack <= 1'b0; mask <= '0; rxb <= '0; presc <= '0;
    end else begin
      if (rx_ok) begin rxb <= rsh[7:0]; rxrdy <= 1'b1; end
      else if (rd_rx) rxrdy <= 1'b0;
      if (wr_tx) begin txrdy <= 1'b0; nack <= 1'b0; end
      else if (tx_done) begin txrdy <= 1'b1; nack <= df; end
      if (reg_wr && reg_addr == A_IEN) mask <= mask | reg_wdata[2:0];
      else if (reg_wr && reg_addr == A_IDIS) mask <= mask & ~reg_wdata[2:0];
      if (reg_wr && reg_addr == A_PS) presc <= reg_wdata[PRESC_W-1:0];
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RX:   reg_rdata[7:0] = rxb;
      A_ST:   reg_rdata[2:0] = {nack, txrdy, rxrdy};
      A_MASK: reg_rdata[2:0] = mask;
      A_PS:   reg_rdata[PRESC_W-1:0] = presc;
      default: reg_rdata = '0;
    endcase
  end

  assign ps2_clk_oe = clk_lo;
  assign ps2_dat_oe = dat_lo;
  assign irq = |({nack, txrdy, rxrdy} & mask);

  // R2
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> ps2_clk_oe && !ps2_dat_oe);
  // R6
  no_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack) |-> txrdy && !ps2_clk_oe);
  // R7
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> !txrdy && !nack);
  // R10
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rx && !rx_ok |=> !rxrdy);
  // R11
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == A_IEN |=> (mask & $past(reg_wdata[2:0])) == $past(reg_wdata[2:0]));
  // R11
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == A_IDIS |=> (mask & $past(reg_wdata[2:0])) == 3'b000);
endmodule

// File: tb/ps2_host_port_test.sv
module ps2_host_port_test;
  localparam int HALF = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dev_clk = 1'b1, dev_dat = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic clk_oe, dat_oe, irq;
  wire bus_clk = dev_clk & ~clk_oe;
  wire bus_dat = dev_dat & ~dat_oe;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ps2_host_port #(.PRESC_W(8), .FILT(3)) uut (
    .clk(clk), .rst_n(rst_n), .ps2_clk_in(bus_clk), .ps2_dat_in(bus_dat),
    .ps2_clk_oe(clk_oe), .ps2_dat_oe(dat_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 clk_oe", clk_oe, 0);
    check("R1 dat_oe", dat_oe, 0);
    check("R1 irq", irq, 0);
    rd(3'd2, v); check("R1 status", v, 16'h2);
    rd(3'd5, v); check("R1 mask", v, 0);
  endtask

  task automatic t_tx(input logic [7:0] b, input bit ack);
    logic [15:0] v;
    logic [9:0] got;
    int n;
    wr(3'd0, {8'h0, b});
    rd(3'd2, v); check("R7 status after write", v[2:1], 0);
    n = 2;
    while (clk_oe) begin
      if (dat_oe) check("R2 data released in inhibit", 1, 0);
      n++; @(negedge clk);
    end
    check("R2 inhibit length", n, 20);
    check("R3 start bit", dat_oe, 1);
    wait_n(10);
    for (int i = 0; i < 10; i++) begin
      dev_clk = 1'b0; wait_n(HALF);
      dev_clk = 1'b1; got[i] = bus_dat; wait_n(HALF);
    end
    check("R4 data bits", got[7:0], b);
    check("R4 parity", got[8], ~^b);
    check("R4 stop", got[9], 1);
    if (ack) dev_dat = 1'b0;
    wait_n(HALF / 2);
    dev_clk = 1'b0; wait_n(HALF);
    dev_clk = 1'b1; wait_n(HALF);
    dev_dat = 1'b1; wait_n(10);
    rd(3'd2, v);
    if (ack) check("R5 status", v[2:1], 2'b01);
    else     check("R6 status", v[2:1], 2'b11);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      if (clk_oe) n++;
      @(negedge clk);
    end
    check("R6 no retry", n, 0);
  endtask

  task automatic send(input logic [7:0] b, input bit bad_par, input bit bad_stop);
    logic [10:0] f;
    f = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      dev_dat = f[i]; wait_n(HALF / 2);
      dev_clk = 1'b0; wait_n(HALF);
      dev_clk = 1'b1; wait_n(HALF / 2);
    end
    dev_dat = 1'b1; wait_n(10);
  endtask

  task automatic t_rx(input logic [7:0] b);
    logic [15:0] v;
    send(b, 0, 0);
    rd(3'd2, v); check("R8 rxrdy set", v[0], 1);
    rd(3'd1, v); check("R8 rx byte", v[7:0], b);
    rd(3'd2, v); check("R10 rxrdy cleared", v[0], 0);
  endtask

  task automatic t_rx_bad;
    logic [15:0] v;
    send(8'h5A, 1, 0);
    rd(3'd2, v); check("R9 bad parity dropped", v[0], 0);
    send(8'h5A, 0, 1);
    rd(3'd2, v); check("R9 bad stop dropped", v[0], 0);
  endtask

  task automatic t_mask_irq;
    logic [15:0] v;
    wr(3'd3, 16'h0005);
    rd(3'd5, v); check("R11 mask set", v, 5);
    check("R12 irq off", irq, 0);
    wr(3'd3, 16'h0002);
    check("R12 irq txrdy", irq, 1);
    wr(3'd4, 16'h0003);
    rd(3'd5, v); check("R11 mask cleared", v, 4);
    check("R12 irq masked", irq, 0);
    wr(3'd3, 16'h0001);
    send(8'h3C, 0, 0);
    check("R12 irq rxrdy", irq, 1);
    rd(3'd1, v);
    check("R12 irq drop after read", irq, 0);
    wr(3'd4, 16'h0007);
  endtask

  task automatic t_glitch;
    logic [15:0] v;
    dev_dat = 1'b0; wait_n(5);
    @(negedge clk); dev_clk = 1'b0;
    @(negedge clk); dev_clk = 1'b1;
    wait_n(5); dev_dat = 1'b1; wait_n(HALF);
    send(8'hC3, 0, 0);
    rd(3'd1, v); check("R13 glitch ignored", v[7:0], 8'hC3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_n(3); rst_n = 1'b1; wait_n(2);
    t_reset;
    wr(3'd6, 16'd20);
    t_tx(8'hA5, 1);
    t_mask_irq;
    t_tx(8'h01, 0);
    t_tx(8'hF0, 1);
    t_rx(8'h96);
    t_rx(8'h00);
    t_rx_bad;
    t_glitch;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule